// File: doc/BRIEF.md
# I2C Register Slave with Strapped Address

This block is an I2C-bus slave that lets a host read and write an external register file of up to 256 byte-wide entries. The seven-bit device address is fixed in its upper six bits; its lowest bit comes from a strap pin. The block samples that pin in the first clock after the active-low reset is released. If no reset has been applied since power-on, the low bit is 0.

A write is one fixed frame: START, the address byte with R/W=0, a register index byte, a data byte, then STOP. The slave acknowledges each of the three bytes and sends a one-cycle write strobe to the register file. To read, the host writes only the register index, issues a repeated START, and sends the address byte with R/W=1. The slave then shifts out the addressed register most significant bit first.

SCL and SDA are synchronised to the system clock. The slave never stretches the clock. It pulls SDA low through an output-enable that the pad turns into an open-drain driver.

Top module: `i2c_strap_regslave`

## Requirements
- R1: The slave responds to the 8-bit address byte {0,1,0,1,1,0,A0,RW} (bit 7 first on the wire, bit 0 = RW, RW=0 write, RW=1 read) and pulls SDA low for the whole ninth SCL clock of a matching byte.
- R2: A0 takes the level of `addr_strap` in the first clock after `rst_n` returns high. Later changes of the pin do not change the address until the next reset.
- R3: From power-on with no reset pulse, A0 is 0. In that state, byte 0x5A gets no acknowledge and byte 0x58 is acknowledged.
- R4: In a write frame, the second byte is the register index and the third byte is the data. After the data byte, `rf_we` is high for exactly one clock with `rf_addr` equal to the index and `rf_wdata` equal to the data, and the data byte is acknowledged.
- R5: After an index-only write, a repeated START and an address byte with RW=1, the slave sends the addressed register content MSB first, one bit per SCL clock.
- R6: When the address byte does not match, the slave does not acknowledge it. It then ignores all bytes until the next START: it never pulls SDA low and never pulses `rf_we`.
- R7: A START or STOP that arrives before the eighth bit of a byte abandons the frame without a write. A following complete frame works normally.
- R8: After reset, and after every STOP, SDA is released (`sda_oe`=0) and `rf_we` is 0.
- R9: During a read, if the host acknowledges a byte, the same register is sent again. If the host does not acknowledge, the slave releases SDA and waits for the next START.
- R10: A fourth byte in a write frame is not acknowledged and is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; its release samples the strap |
| addr_strap | input | 1 | Strap pin giving address bit A0 |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_addr | output | 8 | Register index for read and write |
| rf_wdata | output | 8 | Write data to the register file |
| rf_we | output | 1 | One-cycle write strobe |
| rf_rdata | input | 8 | Register content at `rf_addr`, combinational |

## Verification
Bus-condition detection and byte assembly share the same synchronised samples. A START or STOP can therefore be seen in a cycle where the bit shifter is part-way through a byte. The bench provokes this by sending a STOP after four data bits, and in a second frame a repeated START after four bits. A correct result shows no write strobe for the broken frames, while the complete frame that follows writes exactly once with the right index and data. The write strobe and the start of the acknowledge also fall in the same cycle. The bench judges this by checking, at the ports, the ninth-clock acknowledge together with the captured strobe values.

// File: rtl/i2c_strap_regslave.sv
module i2c_strap_regslave #(
  parameter logic [5:0] ADDR_HI = 6'b010110,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_strap,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] rf_addr,
  output logic [7:0] rf_wdata,
  output logic       rf_we,
  input  logic [7:0] rf_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;

  st_t                  st     = S_IDLE;
  logic [SYNC_STAGES:0] scl_p  = '1;
  logic [SYNC_STAGES:0] sda_p  = '1;
  logic [7:0]           sh     = '0;
  logic [7:0]           tx     = '0;
  logic [7:0]           regptr = '0;
  logic [7:0]           wdata  = '0;
  logic [3:0]           bitcnt = '0;
  logic [1:0]           idx    = '0;
  logic                 rw     = 1'b0;
  logic                 oe     = 1'b0;
  logic                 we     = 1'b0;
  logic                 mack   = 1'b0;
  logic                 rst_q  = 1'b1;
  logic                 a0     = 1'b0;

  wire scl_s = scl_p[SYNC_STAGES-1];
  wire scl_d = scl_p[SYNC_STAGES];
  wire sda_s = sda_p[SYNC_STAGES-1];
  wire sda_d = sda_p[SYNC_STAGES];

  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  assign sda_oe   = oe;
  assign rf_we    = we;
  assign rf_addr  = regptr;
  assign rf_wdata = wdata;

  always_ff @(posedge clk) begin
    rst_q <= rst_n;
    if (rst_n && !rst_q) a0 <= addr_strap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      scl_p  <= '1;
      sda_p  <= '1;
      sh     <= '0;
      tx     <= '0;
      regptr <= '0;
      wdata  <= '0;
      bitcnt <= '0;
      idx    <= '0;
      rw     <= 1'b0;
      oe     <= 1'b0;
      we     <= 1'b0;
      mack   <= 1'b0;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
      we    <= 1'b0;
      if (start_det) begin
        st     <= S_RX;
        bitcnt <= '0;
        idx    <= '0;
        rw     <= 1'b0;
        oe     <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE;
        oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (idx)
                2'd0: begin
                  if (sh[7:1] == {ADDR_HI, a0}) begin
                    rw <= sh[0];
                    oe <= 1'b1;
                    st <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                2'd1: begin
                  regptr <= sh;
                  oe     <= 1'b1;
                  st     <= S_ACK;
                end
                2'd2: begin
                  wdata <= sh;
                  we    <= 1'b1;
                  oe    <= 1'b1;
                  st    <= S_ACK;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                st <= S_TX;
                tx <= rf_rdata;
                oe <= ~rf_rdata[7];
              end else begin
                st  <= S_RX;
                idx <= idx + 2'd1;
                oe  <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                oe <= 1'b0;
                st <= S_MACK;
              end else begin
                tx <= {tx[6:0], 1'b0};
                oe <= ~tx[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                st     <= S_TX;
                tx     <= rf_rdata;
                oe     <= ~rf_rdata[7];
                bitcnt <= '0;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_sda_moves_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !scl_s);

  assert_strap_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && rst_q) |=> $stable(a0));

  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !oe);

  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!oe && st == S_IDLE));

endmodule

// File: tb/sim_i2c_strap_regslave.sv
module sim_i2c_strap_regslave;
  localparam int CLK_P = 10;
  localparam int H = 8;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h00_3C, 16'h01_C3, 16'h7F_80, 16'h80_01, 16'hFF_FF, 16'h42_00};

  logic clk = 1'b0, rst_n = 1'b1, addr_strap = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, rf_we;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  logic [7:0] mem [256];
  logic sda_line;
  int tests = 0, fails = 0, we_cnt = 0, oe_cnt = 0;
  logic [7:0] last_a, last_d;

  always #(CLK_P/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign rf_rdata = mem[rf_addr];

  i2c_strap_regslave u0 (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata));

  always @(posedge clk) begin
    if (rf_we) begin
      mem[rf_addr] <= rf_wdata;
      last_a <= rf_addr;
      last_d <= rf_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart;
    sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H); sda_m = 1'b0; hold(H); scl_m = 1'b0; hold(2);
  endtask

  task automatic bstop;
    sda_m = 1'b0; hold(H); scl_m = 1'b1; hold(H); sda_m = 1'b1; hold(H);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; hold(H); scl_m = 1'b1; hold(H); scl_m = 1'b0; hold(2);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H/2); b = sda_line; hold(H/2); scl_m = 1'b0; hold(2);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
    bit_out(~give_ack);
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] ra, input logic [7:0] dat, output logic [2:0] acks);
    logic a;
    bstart;
    wbyte(dev, a); acks[2] = a;
    wbyte(ra, a);  acks[1] = a;
    wbyte(dat, a); acks[0] = a;
    bstop;
  endtask

  task automatic do_read(input logic [7:0] dev, input logic [7:0] ra, output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    bstart; wbyte(dev, a1); wbyte(ra, a2);
    bstart; wbyte(dev | 8'h01, a3);
    rbyte(1'b0, d);
    bstop;
    ok = a1 & a2 & a3;
  endtask

  task automatic do_reset(input logic pin);
    addr_strap = pin; rst_n = 1'b0; hold(4); rst_n = 1'b1; hold(4);
  endtask

  initial begin
    logic [2:0] acks;
    logic [7:0] d, d2;
    logic ok, a;
    int wc, oc;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    hold(5);

    wc = we_cnt;
    do_write(8'h5A, 8'h10, 8'h77, acks);
    chk("R3 A0=1 not acked at power-on", int'(acks), 0);
    chk("R3 no write", we_cnt, wc);
    do_write(8'h58, 8'h10, 8'h77, acks);
    chk("R3 A0=0 acked at power-on", int'(acks), 7);

    do_reset(1'b1);
    chk("R8 sda released after reset", int'(sda_oe), 0);
    chk("R8 no strobe after reset", int'(rf_we), 0);
    addr_strap = 1'b0;
    do_write(8'h5A, 8'h11, 8'h22, acks);
    chk("R2 strapped A0=1 acked", int'(acks), 7);
    do_write(8'h58, 8'h11, 8'h23, acks);
    chk("R2 later pin change ignored", int'(acks), 0);

    do_reset(1'b0);
    for (int v = 0; v < NV; v++) begin
      wc = we_cnt;
      do_write(8'h58, VEC[v][15:8], VEC[v][7:0], acks);
      chk("R1 three bytes acked", int'(acks), 7);
      chk("R4 single strobe", we_cnt - wc, 1);
      chk("R4 index", int'(last_a), int'(VEC[v][15:8]));
      chk("R4 data", int'(last_d), int'(VEC[v][7:0]));
      do_read(8'h58, VEC[v][15:8], d, ok);
      chk("R5 read acks", int'(ok), 1);
      chk("R5 read data", int'(d), int'(VEC[v][7:0]));
      chk("R8 released after stop", int'(sda_oe), 0);
    end

    wc = we_cnt; oc = oe_cnt;
    do_write(8'h5E, 8'h05, 8'h00, acks);
    chk("R6 mismatch acks", int'(acks), 0);
    chk("R6 no write", we_cnt, wc);
    chk("R6 sda never pulled", oe_cnt, oc);

    wc = we_cnt;
    bstart; wbyte(8'h58, a); wbyte(8'h20, a);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bstop;
    chk("R7 stop mid-byte no write", we_cnt, wc);
    bstart; wbyte(8'h58, a);
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bstart; wbyte(8'h58, a); wbyte(8'h21, a); wbyte(8'h99, a);
    bstop;
    chk("R7 single write after restart", we_cnt - wc, 1);
    chk("R7 write index", int'(last_a), 8'h21);
    chk("R7 write data", int'(last_d), 8'h99);

    bstart; wbyte(8'h58, a); wbyte(8'h01, a);
    bstart; wbyte(8'h59, a);
    rbyte(1'b1, d);
    rbyte(1'b0, d2);
    chk("R9 first byte", int'(d), 8'hC3);
    chk("R9 repeated byte after master ack", int'(d2), 8'hC3);
    hold(H);
    chk("R9 released after master nack", int'(sda_oe), 0);
    bstop;

    wc = we_cnt;
    bstart; wbyte(8'h58, a); wbyte(8'h30, a); wbyte(8'h44, a);
    chk("R10 data acked", int'(a), 1);
    wbyte(8'h55, a);
    chk("R10 fourth byte nacked", int'(a), 0);
    bstop;
    chk("R10 one write", we_cnt - wc, 1);
    do_read(8'h58, 8'h30, d, ok);
    chk("R10 register keeps third byte", int'(d), 8'h44);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule